// File: doc/BRIEF.md
# Atomic Instruction Micro-op Expander

This block sits between the decoder and the memory pipeline of a core. It takes one decoded atomic memory instruction per handshake and turns it into an ordered run of micro-ops, one per cycle. The instruction can be a load-reserved, a store-conditional or a read-modify-write atomic. It carries an acquire bit and a release bit. A set release bit puts a barrier fence in front of the memory micro-op. A set acquire bit puts a barrier fence behind it. Each micro-op leaves with its kind (fence or memory) and four ordering flags: first, last, memory-barrier and delayed-commit. A memory micro-op also carries its access class. An opaque payload taken with the instruction is repeated on every micro-op of its run.

Both ends use valid/ready. The input side takes an instruction only when the previous run has fully drained, so `in_ready` is low from the accept until the last micro-op has been taken. On the output side, a micro-op with `out_valid` high and `out_ready` low stays on the port unchanged until the next cycle. Nothing is dropped or repeated. A separate combinational path turns the memory system's store-conditional success flag into the value written to the destination register.

Top module: `atomic_uop_expander`

## Requirements
- R1: The run is, in order, a release fence (only when release is set), the memory micro-op, then an acquire fence (only when acquire is set). After the last micro-op is taken, `out_valid` is low in the next cycle.
- R2: A release fence has first=1, barrier=1, delayed-commit=1 and last=0.
- R3: The memory micro-op has first=1 exactly when release is clear.
- R4: The memory micro-op has last=1 when acquire is clear. When acquire is set it has last=0 and delayed-commit=1 instead.
- R5: An acquire fence has last=1, barrier=1, first=0 and delayed-commit=0.
- R6: The access class comes from `in_cls`: 0 load-reserved, 1 store-conditional, 2 or 3 read-modify-write. On the memory micro-op this gives `out_load` (class 0), `out_store` (class 1) or `out_amo` (classes 2 and 3), exactly one of them set. On a fence all three are 0. The same expansion rules hold for every class.
- R7: `sc_rd_value` is 0 when `sc_success` is 1, and 1 when `sc_success` is 0, with all upper bits zero.
- R8: `in_ready` is 1 when idle and 0 while micro-ops remain. An instruction offered while `in_ready` is 0 is ignored.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field stays the same in the next cycle.
- R10: A synchronous active-high `rst` brings the block to idle: `out_valid` 0 and `in_ready` 1, even in the middle of a run.
- R11: With acquire and release both clear, the run is a single memory micro-op with first=1 and last=1.
- R12: Every micro-op of a run carries the payload that was accepted with its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Expander idle, can accept |
| in_cls | input | 2 | Access class (0 LR, 1 SC, 2/3 RMW) |
| in_aq | input | 1 | Acquire ordering bit |
| in_rl | input | 1 | Release ordering bit |
| in_payload | input | PAYLOAD_W | Opaque tag repeated on each micro-op |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_is_mem | output | 1 | 1 memory micro-op, 0 fence |
| out_first | output | 1 | First micro-op of the run |
| out_last | output | 1 | Last micro-op of the run |
| out_barrier | output | 1 | Memory-barrier flag |
| out_dcommit | output | 1 | Delayed-commit flag |
| out_amo | output | 1 | Atomic read-modify-write reference |
| out_load | output | 1 | Load access |
| out_store | output | 1 | Store access |
| out_payload | output | PAYLOAD_W | Payload of the current run |
| sc_success | input | 1 | Memory system success flag for a store-conditional |
| sc_rd_value | output | DATA_W | Architectural store-conditional result |

## Verification
The bench builds the block with PAYLOAD_W at 8 and DATA_W at 64. An 8-bit payload lets each table entry tag its own run with a distinct value, so a micro-op that leaked out of a stale or ignored instruction shows up as a wrong tag. The 64-bit result width checks that the inverted flag lands in bit 0 alone, with all 63 upper bits zero. Every class is run with all four acquire/release combinations. Stalls are placed on chosen slots, and there are directed cases for a mid-run reset and for an instruction offered while busy.

// File: rtl/amo_uop_pkg.sv
package amo_uop_pkg;

  localparam int unsigned SEQ_MAX   = 3;
  localparam int unsigned SEQ_IDX_W = $clog2(SEQ_MAX);

  typedef enum logic [1:0] {
    CLS_LR  = 2'd0,
    CLS_SC  = 2'd1,
    CLS_RMW = 2'd2,
    CLS_RSV = 2'd3
  } amo_class_e;

  typedef enum logic [1:0] {
    SLOT_REL = 2'd0,
    SLOT_MEM = 2'd1,
    SLOT_ACQ = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  typedef struct packed {
    logic is_mem;
    logic first;
    logic last;
    logic barrier;
    logic dcommit;
    logic amo;
    logic load;
    logic store;
  } uop_flags_t;

endpackage

// File: rtl/amo_seq_ctrl.sv
module amo_seq_ctrl
  import amo_uop_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_cls,
  input  logic                 in_aq,
  input  logic                 in_rl,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 busy,
  input  logic                 out_ready,
  output slot_e                cur_slot,
  output amo_class_e           cur_cls,
  output logic                 cur_aq,
  output logic                 cur_rl,
  output logic [PAYLOAD_W-1:0] cur_payload
);

  logic [SEQ_IDX_W-1:0] idx_q;
  logic [SEQ_IDX_W-1:0] last_idx;
  logic [SEQ_IDX_W-1:0] pos;
  logic                 accept;
  logic                 advance;
  logic                 at_end;

  assign accept   = in_valid && in_ready;
  assign advance  = busy && out_ready;
  assign last_idx = SEQ_IDX_W'(cur_aq) + SEQ_IDX_W'(cur_rl);
  assign at_end   = (idx_q == last_idx);
  assign in_ready = !busy;

  // Slot position: a run without a release fence starts at the memory slot.
  assign pos = idx_q + (cur_rl ? SEQ_IDX_W'(0) : SEQ_IDX_W'(1));

  always_comb begin
    case (pos)
      2'd0:    cur_slot = SLOT_REL;
      2'd1:    cur_slot = SLOT_MEM;
      2'd2:    cur_slot = SLOT_ACQ;
      default: cur_slot = SLOT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      idx_q       <= '0;
      cur_aq      <= 1'b0;
      cur_rl      <= 1'b0;
      cur_cls     <= CLS_LR;
      cur_payload <= '0;
    end else if (accept) begin
      busy        <= 1'b1;
      idx_q       <= '0;
      cur_aq      <= in_aq;
      cur_rl      <= in_rl;
      cur_cls     <= amo_class_e'(in_cls);
      cur_payload <= in_payload;
    end else if (advance) begin
      if (at_end) begin
        busy  <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + SEQ_IDX_W'(1);
      end
    end
  end

  // R8: an accepted instruction produces a valid micro-op next cycle
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R9: a stalled slot does not move
  a_r9_idx_hold: assert property (@(posedge clk) disable iff (rst)
    busy && !out_ready |=> busy && $stable(idx_q) && $stable(cur_payload));

  // R1: the run ends after its final slot is taken
  a_r1_drain: assert property (@(posedge clk) disable iff (rst)
    advance && at_end |=> !busy);

  // R10: reset clears the run
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> !busy);

endmodule

// File: rtl/amo_slot_decode.sv
module amo_slot_decode
  import amo_uop_pkg::*;
(
  input  slot_e      slot,
  input  amo_class_e cls,
  input  logic       aq,
  input  logic       rl,
  output uop_flags_t flags
);

  always_comb begin
    flags = '0;
    unique case (slot)
      SLOT_REL: begin
        flags.first   = 1'b1;
        flags.barrier = 1'b1;
        flags.dcommit = 1'b1;
      end
      SLOT_MEM: begin
        flags.is_mem  = 1'b1;
        flags.first   = !rl;
        flags.last    = !aq;
        flags.dcommit = aq;
        flags.load    = (cls == CLS_LR);
        flags.store   = (cls == CLS_SC);
        flags.amo     = (cls == CLS_RMW) || (cls == CLS_RSV);
      end
      SLOT_ACQ: begin
        flags.last    = 1'b1;
        flags.barrier = 1'b1;
      end
      default: flags = '0;
    endcase
  end

endmodule

// File: rtl/amo_sc_result.sv
module amo_sc_result #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              success,
  output logic [DATA_W-1:0] rd_value
);

  generate
    if (DATA_W == 1) begin : g_narrow
      assign rd_value = ~success;
    end else begin : g_wide
      assign rd_value = {{(DATA_W-1){1'b0}}, ~success};
    end
  endgenerate

endmodule

// File: rtl/atomic_uop_expander.sv
module atomic_uop_expander
  import amo_uop_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 8,
  parameter int unsigned DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_cls,
  input  logic                 in_aq,
  input  logic                 in_rl,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_is_mem,
  output logic                 out_first,
  output logic                 out_last,
  output logic                 out_barrier,
  output logic                 out_dcommit,
  output logic                 out_amo,
  output logic                 out_load,
  output logic                 out_store,
  output logic [PAYLOAD_W-1:0] out_payload,
  input  logic                 sc_success,
  output logic [DATA_W-1:0]    sc_rd_value
);

  slot_e      cur_slot;
  amo_class_e cur_cls;
  logic       cur_aq;
  logic       cur_rl;
  uop_flags_t flags;

  amo_seq_ctrl #(.PAYLOAD_W(PAYLOAD_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_cls      (in_cls),
    .in_aq       (in_aq),
    .in_rl       (in_rl),
    .in_payload  (in_payload),
    .busy        (out_valid),
    .out_ready   (out_ready),
    .cur_slot    (cur_slot),
    .cur_cls     (cur_cls),
    .cur_aq      (cur_aq),
    .cur_rl      (cur_rl),
    .cur_payload (out_payload)
  );

  amo_slot_decode u_dec (
    .slot  (cur_slot),
    .cls   (cur_cls),
    .aq    (cur_aq),
    .rl    (cur_rl),
    .flags (flags)
  );

  amo_sc_result #(.DATA_W(DATA_W)) u_sc (
    .success  (sc_success),
    .rd_value (sc_rd_value)
  );

  assign out_is_mem  = flags.is_mem;
  assign out_first   = flags.first;
  assign out_last    = flags.last;
  assign out_barrier = flags.barrier;
  assign out_dcommit = flags.dcommit;
  assign out_amo     = flags.amo;
  assign out_load    = flags.load;
  assign out_store   = flags.store;

  // R2: a leading fence is a delayed-commit barrier
  a_r2_rel_fence: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_mem && out_first |-> out_barrier && out_dcommit && !out_last);

  // R5: a trailing fence closes the run
  a_r5_acq_fence: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_mem && !out_first |-> out_last && out_barrier && !out_dcommit);

  // R4: the memory micro-op is either last or delayed-commit
  a_r4_mem_tail: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_mem |-> (out_last != out_dcommit) && !out_barrier);

  // R6: exactly one access class on memory, none on fences
  a_r6_class: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_is_mem ? $countones({out_amo, out_load, out_store}) == 1
                              : {out_amo, out_load, out_store} == 3'b000));

  // R11: a first-and-last micro-op can only be the lone memory op
  a_r11_single: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_first && out_last |-> out_is_mem);

  // R9: stalled outputs hold
  a_r9_out_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(flags) && $stable(out_payload));

  // R1: last taken closes the run
  a_r1_end: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

endmodule

// File: tb/sim_atomic_uop_expander.sv
module sim_atomic_uop_expander;

  localparam int PW = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_cls = 2'd0;
  logic in_aq = 1'b0;
  logic in_rl = 1'b0;
  logic [PW-1:0] in_payload = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic out_is_mem, out_first, out_last, out_barrier, out_dcommit;
  logic out_amo, out_load, out_store;
  logic [PW-1:0] out_payload;
  logic sc_success = 1'b0;
  logic [DW-1:0] sc_rd_value;

  always #10 clk = ~clk;

  atomic_uop_expander #(.PAYLOAD_W(PW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_aq(in_aq), .in_rl(in_rl), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_mem(out_is_mem),
    .out_first(out_first), .out_last(out_last), .out_barrier(out_barrier),
    .out_dcommit(out_dcommit), .out_amo(out_amo), .out_load(out_load),
    .out_store(out_store), .out_payload(out_payload),
    .sc_success(sc_success), .sc_rd_value(sc_rd_value)
  );

  // Vector: {cls[1:0], aq, rl, len[1:0], mem_mask[2:0]}
  localparam int NV = 12;
  localparam logic [8:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 2'd1, 3'b001},
    {2'd0, 1'b0, 1'b1, 2'd2, 3'b010},
    {2'd0, 1'b1, 1'b0, 2'd2, 3'b001},
    {2'd0, 1'b1, 1'b1, 2'd3, 3'b010},
    {2'd1, 1'b0, 1'b0, 2'd1, 3'b001},
    {2'd1, 1'b0, 1'b1, 2'd2, 3'b010},
    {2'd1, 1'b1, 1'b0, 2'd2, 3'b001},
    {2'd1, 1'b1, 1'b1, 2'd3, 3'b010},
    {2'd2, 1'b0, 1'b0, 2'd1, 3'b001},
    {2'd3, 1'b0, 1'b1, 2'd2, 3'b010},
    {2'd2, 1'b1, 1'b0, 2'd2, 3'b001},
    {2'd2, 1'b1, 1'b1, 2'd3, 3'b010}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cur_flags();
    return {out_is_mem, out_first, out_last, out_barrier, out_dcommit, out_amo, out_load, out_store};
  endfunction

  // Expected flags from the requirements; pos 0 release fence, 1 memory, 2 acquire fence
  function automatic logic [7:0] exp_flags(input int pos, input logic [1:0] cls, input logic aq, input logic rl);
    logic [7:0] f;
    f = '0;
    if (pos == 0) f = 8'b0101_1000;
    else if (pos == 2) f = 8'b0011_0000;
    else begin
      f[7] = 1'b1; f[6] = !rl; f[5] = !aq; f[3] = aq;
      f[2] = (cls >= 2'd2); f[1] = (cls == 2'd0); f[0] = (cls == 2'd1);
    end
    return f;
  endfunction

  task automatic offer(input logic [1:0] c, input logic a, input logic r, input logic [PW-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_cls = c; in_aq = a; in_rl = r; in_payload = p;
    chk(in_ready === 1'b1, "R8 idle ready", {63'b0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] hold;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset out_valid", {63'b0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R10 reset in_ready", {63'b0, in_ready}, 64'd1);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6 R9 R11 R12
    for (int e = 0; e < NV; e++) begin
      logic [1:0] c; logic a; logic r; int len; logic [2:0] mm;
      c = VEC[e][8:7]; a = VEC[e][6]; r = VEC[e][5]; len = int'(VEC[e][4:3]); mm = VEC[e][2:0];
      offer(c, a, r, PW'(e + 8'h40));
      for (int k = 0; k < len; k++) begin
        int pos;
        pos = r ? k : k + 1;
        chk(out_valid === 1'b1, "R1 valid in run", {63'b0, out_valid}, 64'd1);
        chk(in_ready === 1'b0, "R8 busy not ready", {63'b0, in_ready}, 64'd0);
        if ((e % 3) == 1 && k == 0) begin
          out_ready = 1'b0;
          hold = cur_flags();
          @(negedge clk);
          chk(cur_flags() === hold && out_valid === 1'b1, "R9 stall hold", {56'b0, cur_flags()}, {56'b0, hold});
        end
        out_ready = 1'b1;
        chk(out_is_mem === mm[k], "R1 slot kind", {63'b0, out_is_mem}, {63'b0, mm[k]});
        chk(cur_flags() === exp_flags(pos, c, a, r),
            pos == 0 ? "R2 release fence" : (pos == 2 ? "R5 acquire fence" : "R3 R4 R6 memory op"),
            {56'b0, cur_flags()}, {56'b0, exp_flags(pos, c, a, r)});
        chk(out_payload === PW'(e + 8'h40), "R12 payload", {56'b0, out_payload}, {56'b0, PW'(e + 8'h40)});
        if (len == 1)
          chk(out_first === 1'b1 && out_last === 1'b1, "R11 single first+last",
              {62'b0, out_first, out_last}, 64'd3);
        @(negedge clk);
      end
      out_ready = 1'b0;
      chk(out_valid === 1'b0, "R1 drained", {63'b0, out_valid}, 64'd0);
    end

    // R8: instruction offered while busy is ignored
    offer(2'd2, 1'b1, 1'b1, 8'hA5);
    in_valid = 1'b1; in_cls = 2'd0; in_aq = 1'b0; in_rl = 1'b0; in_payload = 8'h3C;
    repeat (2) begin
      chk(in_ready === 1'b0, "R8 ready low busy", {63'b0, in_ready}, 64'd0);
      chk(out_payload === 8'hA5 && out_is_mem === 1'b0, "R8 ignored offer",
          {55'b0, out_is_mem, out_payload}, {55'b0, 1'b0, 8'hA5});
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(out_valid === 1'b1 && out_payload === 8'hA5, "R8 old run intact",
          {55'b0, out_valid, out_payload}, {55'b0, 1'b1, 8'hA5});
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R8 no second run", {63'b0, out_valid}, 64'd0);

    // R10: reset in the middle of a run
    offer(2'd1, 1'b1, 1'b1, 8'h77);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_valid === 1'b0, "R10 mid-run reset valid", {63'b0, out_valid}, 64'd0);
    chk(in_ready === 1'b1, "R10 mid-run reset ready", {63'b0, in_ready}, 64'd1);

    // R7: store-conditional result mapping
    sc_success = 1'b1; #1;
    chk(sc_rd_value === 64'd0, "R7 success gives 0", sc_rd_value, 64'd0);
    sc_success = 1'b0; #1;
    chk(sc_rd_value === 64'd1, "R7 failure gives 1", sc_rd_value, 64'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule